// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block stands between an 8-bit microcontroller bus and a small on-chip flash array that is modelled as registers and split into equal sectors. Writes to the block do not store data. Each write is one step of a keyed command sequence. A sequence that matches in full starts a timed background operation: a byte program, a sector erase or a whole-array erase. A sequence that goes wrong at any step is dropped. Every sector has a protection input, and a program or erase aimed at a protected sector does nothing.

While an operation runs, reads return a status byte instead of array contents. Bit 7 is the complement of the bit-7 value being written. Bit 6 flips on every read. Bit 5 reports a sticky error. Software finds out that the operation has finished by polling until bit 7 shows the true value or bit 6 stops changing. With the default parameters there are 8 sectors of 16 bytes. The array index is address bits [6:0] and the sector number is address bits [6:4].

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is idle (`busy` low) and every array byte reads FFh. A read strobe in one cycle returns its byte on `bus_rdata` from the next cycle on.
- R2: A program runs only after these four writes in order: AAh with address bits [11:0] = 555h, then 55h at AAAh, then A0h at 555h, then the data byte at the target address. Address bits above bit 11 are ignored in the key steps.
- R3: A program stores the old byte ANDed with the written byte, so it can only clear bits.
- R4: `busy` stays high for PROG_CYC cycles after a program is accepted. It stays high for ERASE_CYC cycles for each sector that an erase clears.
- R5: While `busy` is high, a read returns a status byte. Bit 7 is the complement of the written bit 7 for a program and 0 for an erase. Bit 6 inverts on every read. Bit 5 is the error flag. Bits 4:0 are 0.
- R6: The sequence AAh@555h, 55h@AAAh, 80h@555h, AAh@555h, 55h@AAAh, then 30h at any address inside a sector sets that whole sector to FFh. No other sector changes.
- R7: The same five-write prefix followed by 10h@555h sets every unprotected sector to FFh, one sector after another.
- R8: A wrong data byte or key address at any step drops the sequence. No array byte changes and `busy` stays low.
- R9: When `sect_prot[s]` is 1, a program or sector erase aimed at sector s is ignored: `busy` stays low and the data is kept. A whole-array erase skips sector s.
- R10: Every write made while `busy` is high is ignored, and so does not advance a sequence.
- R11: A write of F0h while idle returns the decoder to its first step and clears the error flag.
- R12: A program that asks to turn a stored 0 bit into 1 sets the error flag. The flag stays set until an F0h write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, one step per cycle |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| sect_prot | input | NUM_SECT | Per-sector protection, 1 = locked |
| bus_rdata | output | 8 | Registered read data or status byte |
| busy | output | 1 | An embedded operation is running |

## Verification
The assertions check properties that hold on every cycle:
- Bit 6 flips between back-to-back status reads.
- The low status bits are zero.
- `busy` only rises after a write.
- No operation starts while `busy` is high.
- A program to a protected sector never raises `busy`.
- A busy period never runs longer than a full-array erase.

The bench's scenarios are the only place where the following can be shown against a reference byte array:
- The AND rule of programming.
- The exact busy lengths.
- Which sectors an erase clears.
- Dropped and reset sequences.
- The sticky error flag.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PROG,
        SQ_ESET,
        SQ_EUNL1,
        SQ_EUNL2
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_ERASE
    } op_kind_e;

    localparam logic [7:0]  KEY_FIRST  = 8'hAA;
    localparam logic [7:0]  KEY_SECOND = 8'h55;
    localparam logic [7:0]  CMD_PROG   = 8'hA0;
    localparam logic [7:0]  CMD_ESETUP = 8'h80;
    localparam logic [7:0]  CMD_SECT   = 8'h30;
    localparam logic [7:0]  CMD_BULK   = 8'h10;
    localparam logic [7:0]  CMD_RESET  = 8'hF0;
    localparam logic [11:0] ADR_KEY1   = 12'h555;
    localparam logic [11:0] ADR_KEY2   = 12'hAAA;

endpackage

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
    import flash_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [11:0] key_addr,
    input  logic [7:0]  wdata,
    input  logic        busy,
    output logic        go_prog,
    output logic        go_serase,
    output logic        go_bulk,
    output logic        go_reset
);

    typedef struct packed {
        seq_state_e st;
    } dec_t;

    dec_t dec_d, dec_q;
    logic at_k1, at_k2;

    always_comb begin
        dec_d     = dec_q;
        go_prog   = 1'b0;
        go_serase = 1'b0;
        go_bulk   = 1'b0;
        go_reset  = 1'b0;
        at_k1     = (key_addr == ADR_KEY1);
        at_k2     = (key_addr == ADR_KEY2);
        if (wr_en && !busy) begin
            if (wdata == CMD_RESET) begin
                dec_d.st = SQ_IDLE;
                go_reset = 1'b1;
            end else begin
                dec_d.st = SQ_IDLE;
                case (dec_q.st)
                    SQ_IDLE:  if (wdata == KEY_FIRST && at_k1)  dec_d.st = SQ_UNL1;
                    SQ_UNL1:  if (wdata == KEY_SECOND && at_k2) dec_d.st = SQ_UNL2;
                    SQ_UNL2: begin
                        if (at_k1 && wdata == CMD_PROG)        dec_d.st = SQ_PROG;
                        else if (at_k1 && wdata == CMD_ESETUP) dec_d.st = SQ_ESET;
                    end
                    SQ_PROG:  go_prog = 1'b1;
                    SQ_ESET:  if (wdata == KEY_FIRST && at_k1)  dec_d.st = SQ_EUNL1;
                    SQ_EUNL1: if (wdata == KEY_SECOND && at_k2) dec_d.st = SQ_EUNL2;
                    SQ_EUNL2: begin
                        if (wdata == CMD_SECT)               go_serase = 1'b1;
                        else if (wdata == CMD_BULK && at_k1) go_bulk   = 1'b1;
                    end
                    default: dec_d.st = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '{st: SQ_IDLE};
        else        dec_q <= dec_d;
    end

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
    import flash_cmd_pkg::*;
#(
    parameter int NUM_SECT   = 8,
    parameter int SECT_BYTES = 16,
    parameter int PROG_CYC   = 8,
    parameter int ERASE_CYC  = 64,
    localparam int SB_W   = $clog2(SECT_BYTES),
    localparam int SEC_W  = $clog2(NUM_SECT),
    localparam int IDX_W  = SB_W + SEC_W,
    localparam int DEPTH  = NUM_SECT * SECT_BYTES,
    localparam int MAXC   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
    localparam int CNT_W  = $clog2(MAXC + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go_prog,
    input  logic                go_serase,
    input  logic                go_bulk,
    input  logic                go_reset,
    input  logic [IDX_W-1:0]    idx_in,
    input  logic [7:0]          wdata,
    input  logic [NUM_SECT-1:0] sect_prot,
    input  logic                rd_en,
    output logic [7:0]          rdata,
    output logic                busy
);

    typedef struct packed {
        op_kind_e            op;
        logic [CNT_W-1:0]    cnt;
        logic [IDX_W-1:0]    idx;
        logic [7:0]          data;
        logic [NUM_SECT-1:0] pend;
        logic                tog;
        logic                err;
        logic [7:0]          rdata;
    } eng_t;

    eng_t       eng_d, eng_q;
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    logic [SEC_W-1:0]    sec_in, cur_sec;
    logic [NUM_SECT-1:0] mask, one_sec;

    function automatic logic [SEC_W-1:0] lowest(input logic [NUM_SECT-1:0] p);
        logic [SEC_W-1:0] r = '0;
        for (int s = NUM_SECT - 1; s >= 0; s--)
            if (p[s]) r = SEC_W'(s);
        return r;
    endfunction

    always_comb begin
        eng_d   = eng_q;
        mem_d   = mem_q;
        sec_in  = idx_in[IDX_W-1:SB_W];
        one_sec = '0;
        one_sec[sec_in] = 1'b1;
        mask    = (go_bulk ? {NUM_SECT{1'b1}} : one_sec) & ~sect_prot;
        cur_sec = lowest(eng_q.pend);
        if (go_reset) eng_d.err = 1'b0;
        case (eng_q.op)
            OP_NONE: begin
                if (go_prog && !sect_prot[sec_in]) begin
                    eng_d.op   = OP_PROG;
                    eng_d.cnt  = CNT_W'(PROG_CYC - 1);
                    eng_d.idx  = idx_in;
                    eng_d.data = wdata;
                    if ((~mem_q[idx_in] & wdata) != 8'h00) eng_d.err = 1'b1;
                end else if ((go_serase || go_bulk) && mask != '0) begin
                    eng_d.op   = OP_ERASE;
                    eng_d.pend = mask;
                    eng_d.cnt  = CNT_W'(ERASE_CYC - 1);
                end
            end
            OP_PROG: begin
                if (eng_q.cnt == '0) begin
                    mem_d[eng_q.idx] = mem_q[eng_q.idx] & eng_q.data;
                    eng_d.op = OP_NONE;
                end else begin
                    eng_d.cnt = eng_q.cnt - 1'b1;
                end
            end
            OP_ERASE: begin
                if (eng_q.cnt == '0) begin
                    for (int i = 0; i < DEPTH; i++)
                        if (SEC_W'(i / SECT_BYTES) == cur_sec) mem_d[i] = 8'hFF;
                    eng_d.pend[cur_sec] = 1'b0;
                    eng_d.cnt = CNT_W'(ERASE_CYC - 1);
                    if (eng_d.pend == '0) eng_d.op = OP_NONE;
                end else begin
                    eng_d.cnt = eng_q.cnt - 1'b1;
                end
            end
            default: eng_d.op = OP_NONE;
        endcase
        if (rd_en) begin
            if (eng_q.op != OP_NONE) begin
                eng_d.tog   = ~eng_q.tog;
                eng_d.rdata = {(eng_q.op == OP_PROG) ? ~eng_q.data[7] : 1'b0,
                               ~eng_q.tog, eng_q.err, 5'b00000};
            end else begin
                eng_d.rdata = mem_q[idx_in];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{op: OP_NONE, default: '0};
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            eng_q <= eng_d;
            mem_q <= mem_d;
        end
    end

    assign rdata = eng_q.rdata;
    assign busy  = (eng_q.op != OP_NONE);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
    parameter int ADDR_W     = 16,
    parameter int NUM_SECT   = 8,
    parameter int SECT_BYTES = 16,
    parameter int PROG_CYC   = 8,
    parameter int ERASE_CYC  = 64,
    localparam int IDX_W = $clog2(NUM_SECT) + $clog2(SECT_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic                bus_re,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    input  logic [NUM_SECT-1:0] sect_prot,
    output logic [7:0]          bus_rdata,
    output logic                busy
);

    logic go_prog, go_serase, go_bulk, go_reset;

    flash_seq_decoder u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_we),
        .key_addr  (bus_addr[11:0]),
        .wdata     (bus_wdata),
        .busy      (busy),
        .go_prog   (go_prog),
        .go_serase (go_serase),
        .go_bulk   (go_bulk),
        .go_reset  (go_reset)
    );

    flash_op_engine #(
        .NUM_SECT   (NUM_SECT),
        .SECT_BYTES (SECT_BYTES),
        .PROG_CYC   (PROG_CYC),
        .ERASE_CYC  (ERASE_CYC)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_prog   (go_prog),
        .go_serase (go_serase),
        .go_bulk   (go_bulk),
        .go_reset  (go_reset),
        .idx_in    (bus_addr[IDX_W-1:0]),
        .wdata     (bus_wdata),
        .sect_prot (sect_prot),
        .rd_en     (bus_re),
        .rdata     (bus_rdata),
        .busy      (busy)
    );

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
    parameter int ADDR_W     = 16,
    parameter int NUM_SECT   = 8,
    parameter int SECT_BYTES = 16,
    parameter int ERASE_CYC  = 64,
    localparam int SB_W   = $clog2(SECT_BYTES),
    localparam int IDX_W  = SB_W + $clog2(NUM_SECT),
    localparam int MAXRUN = NUM_SECT * ERASE_CYC
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_we,
    input logic                bus_re,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [7:0]          bus_rdata,
    input logic [NUM_SECT-1:0] sect_prot,
    input logic                busy,
    input logic                go_prog,
    input logic                go_serase,
    input logic                go_bulk
);

    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && busy && $past(bus_re) && $past(busy))
        |=> (bus_rdata[6] != $past(bus_rdata[6])));

    assert_status_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && busy) |=> (bus_rdata[4:0] == 5'b00000));

    assert_start_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_we));

    assert_prot_prog_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (go_prog && !busy && sect_prot[bus_addr[IDX_W-1:SB_W]]) |=> !busy);

    assert_no_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(go_prog || go_serase || go_bulk));

    assert_busy_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < MAXRUN));

endmodule

bind flash_cmd_ctrl flash_cmd_chk #(
    .ADDR_W     (ADDR_W),
    .NUM_SECT   (NUM_SECT),
    .SECT_BYTES (SECT_BYTES),
    .ERASE_CYC  (ERASE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .sect_prot (sect_prot),
    .busy      (busy),
    .go_prog   (go_prog),
    .go_serase (go_serase),
    .go_bulk   (go_bulk)
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;

    localparam int ADDR_W = 16;
    localparam int NSEC   = 8;
    localparam int SBYTES = 16;
    localparam int PCYC   = 8;
    localparam int ECYC   = 64;
    localparam int DEPTH  = NSEC * SBYTES;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [NSEC-1:0]   sect_prot = '0;
    logic [7:0]        bus_rdata;
    logic              busy;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;

    logic [7:0] ref_mem [DEPTH];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       want_chk = 1'b0;
    logic       chk_pend = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_ctrl #(
        .ADDR_W(ADDR_W), .NUM_SECT(NSEC), .SECT_BYTES(SBYTES),
        .PROG_CYC(PCYC), .ERASE_CYC(ECYC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sect_prot(sect_prot),
        .bus_rdata(bus_rdata), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compares scoreboard entries as read data appears
    always @(posedge clk) chk_pend <= bus_re && want_chk;
    always @(negedge clk) begin
        if (chk_pend) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard underflow", 0, 1);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata == e, t, bus_rdata, e);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            vectors++;
            $display("FAIL watchdog: actual %0d expected <150000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_ref(input logic [ADDR_W-1:0] a, input string t);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a; want_chk = 1'b1;
        exp_q.push_back(ref_mem[a % DEPTH]);
        tag_q.push_back(t);
        @(negedge clk);
        bus_re = 1'b0; want_chk = 1'b0;
    endtask

    task automatic rd_raw(input logic [ADDR_W-1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        v = bus_rdata;
    endtask

    task automatic poll_done(input logic [ADDR_W-1:0] a);
        logic [7:0] x, y;
        for (int n = 0; n < 4000; n++) begin
            rd_raw(a, x);
            rd_raw(a, y);
            if (x == y && !busy) break;
        end
    endtask

    task automatic unlock();
        wr(16'h0555, 8'hAA);
        wr(16'h0AAA, 8'h55);
    endtask

    task automatic seq_prog(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        unlock();
        wr(16'h0555, 8'hA0);
        wr(a, d);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(16'h0555, 8'h80);
        unlock();
    endtask

    task automatic measure(output int n);
        n = 0;
        while (busy && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic ref_erase(input int s);
        for (int i = 0; i < SBYTES; i++) ref_mem[s * SBYTES + i] = 8'hFF;
    endtask

    initial begin
        logic [7:0] s1, s2;
        int n;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(busy == 1'b0, "R1 idle after reset", busy, 0);
        rd_ref(16'h0000, "R1 byte 0 erased");
        rd_ref(16'(DEPTH - 1), "R1 last byte erased");

        // R2 with upper address bits set; R5 status during program
        unlock();
        wr(16'hF555, 8'hA0);
        wr(16'hC013, 8'h5A);
        rd_raw(16'h0013, s1);
        rd_raw(16'h0013, s2);
        check(s1[7] == 1'b1, "R5 DQ7 complement", s1[7], 1);
        check(s1[6] != s2[6], "R5 DQ6 toggles", s2[6], ~s1[6]);
        check(s1[5] == 1'b0, "R12 no error", s1[5], 0);
        check(s1[4:0] == 5'b0, "R5 low bits zero", s1[4:0], 0);
        poll_done(16'h0013);
        ref_mem[8'h13] &= 8'h5A;
        rd_ref(16'h0013, "R2 program upper bits ignored");

        // R4: program busy length
        seq_prog(16'h0020, 8'h3C);
        measure(n);
        check(n == PCYC, "R4 program busy length", n, PCYC);
        ref_mem[8'h20] &= 8'h3C;
        rd_ref(16'h0020, "R4 program stored");

        // R3 and R12: 0->1 request gives AND result and error flag
        seq_prog(16'h0013, 8'h0F);
        rd_raw(16'h0013, s1);
        check(s1[5] == 1'b1, "R12 error flag set", s1[5], 1);
        poll_done(16'h0013);
        ref_mem[8'h13] &= 8'h0F;
        rd_ref(16'h0013, "R3 AND of old and new");

        // R12 sticky, R11 clears
        seq_prog(16'h0021, 8'hC3);
        rd_raw(16'h0021, s1);
        check(s1[5] == 1'b1, "R12 error flag sticky", s1[5], 1);
        poll_done(16'h0021);
        ref_mem[8'h21] &= 8'hC3;
        wr(16'h0000, 8'hF0);
        seq_prog(16'h0022, 8'h81);
        rd_raw(16'h0022, s1);
        check(s1[5] == 1'b0, "R11 reset clears error", s1[5], 0);
        check(s1[7] == 1'b0, "R5 DQ7 complement of 1", s1[7], 0);
        poll_done(16'h0022);
        ref_mem[8'h22] &= 8'h81;
        rd_ref(16'h0021, "R12 program under error stored");
        rd_ref(16'h0022, "R11 program after reset");

        // R10: writes while busy ignored
        seq_prog(16'h0030, 8'h11);
        unlock();
        wr(16'h0555, 8'hA0);
        poll_done(16'h0030);
        ref_mem[8'h30] &= 8'h11;
        wr(16'h0031, 8'h22);
        check(busy == 1'b0, "R10 busy writes not counted", busy, 0);
        rd_ref(16'h0030, "R10 first program stored");
        rd_ref(16'h0031, "R10 second program dropped");

        // R8: wrong command byte at last erase step
        erase_prefix();
        wr(16'h0010, 8'h33);
        check(busy == 1'b0, "R8 bad erase byte", busy, 0);
        rd_ref(16'h0013, "R8 sector kept");
        // R8: wrong second key
        wr(16'h0555, 8'hAA);
        wr(16'h0AAA, 8'h54);
        wr(16'h0555, 8'hA0);
        wr(16'h0014, 8'h00);
        check(busy == 1'b0, "R8 bad key no busy", busy, 0);
        rd_ref(16'h0014, "R8 bad key data kept");

        // R11: F0 mid-sequence resets decoder
        unlock();
        wr(16'h0555, 8'hF0);
        wr(16'h0555, 8'hA0);
        wr(16'h0015, 8'h00);
        check(busy == 1'b0, "R11 mid reset no busy", busy, 0);
        rd_ref(16'h0015, "R11 mid reset data kept");

        // R6 + R4: sector erase of sector 1 via address inside it
        seq_prog(16'h0005, 8'h66);
        poll_done(16'h0005);
        ref_mem[8'h05] &= 8'h66;
        erase_prefix();
        wr(16'h001F, 8'h30);
        measure(n);
        check(n == ECYC, "R4 sector erase busy length", n, ECYC);
        ref_erase(1);
        rd_ref(16'h0013, "R6 sector 1 erased");
        rd_ref(16'h0005, "R6 sector 0 untouched");
        rd_ref(16'h0020, "R6 sector 2 untouched");

        // R9: protected sector 3
        sect_prot = 8'b0000_1000;
        seq_prog(16'h0032, 8'h00);
        check(busy == 1'b0, "R9 protected program", busy, 0);
        erase_prefix();
        wr(16'h0033, 8'h30);
        check(busy == 1'b0, "R9 protected erase", busy, 0);
        rd_ref(16'h0032, "R9 protected byte kept");
        rd_ref(16'h0030, "R9 protected sector kept");

        // R7 + R4: bulk erase skips protected sector
        erase_prefix();
        wr(16'h8555, 8'h10);
        measure(n);
        check(n == (NSEC - 1) * ECYC, "R4 bulk busy length", n, (NSEC - 1) * ECYC);
        for (int s = 0; s < NSEC; s++) if (s != 3) ref_erase(s);
        rd_ref(16'h0005, "R7 sector 0 erased");
        rd_ref(16'h0020, "R7 sector 2 erased");
        rd_ref(16'h0030, "R7 protected sector kept");

        // R9: bulk with all sectors protected does nothing
        sect_prot = '1;
        erase_prefix();
        wr(16'h0555, 8'h10);
        check(busy == 1'b0, "R9 all protected bulk", busy, 0);

        // R5: erase status DQ7 = 0
        sect_prot = '0;
        erase_prefix();
        wr(16'h0035, 8'h30);
        rd_raw(16'h0035, s1);
        check(s1[7] == 1'b0, "R5 erase DQ7 zero", s1[7], 0);
        check(s1[4:0] == 5'b0, "R5 erase low bits", s1[4:0], 0);
        poll_done(16'h0035);
        ref_erase(3);
        rd_ref(16'h0030, "R6 sector 3 erased");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule